// File: doc/BRIEF.md
# Shared Reset and Power-Down Sequencer

This block watches one active-low input pin that serves two purposes. Any falling edge on the pin resets the device. If the pin then stays low long enough, the device also powers down. The block synchronizes the pin to the modulator clock and counts how many cycles the pin stays low. A short pulse therefore gives only a reset. A long hold gives a reset followed by power-down.

Two other sources feed the block. The first is a reset strobe from the serial command decoder, which the decoder raises on the eighth falling serial-clock edge of the reset opcode byte. The second is a register-write notification: a write that lands on one of three filter-related configuration addresses clears the digital filter.

After every reset the block holds the configuration registers at their defaults for a fixed initialization window and then issues a one-cycle conversion-start pulse. Leaving power-down runs the same sequence, so the registers always come back at their defaults and the host must program them again.

Top module: `pdrst_seq`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `pwr_dn`, `conv_start` and `filt_rst` are 0 and `cfg_rst` and `init_busy` are 1. The power-on initialization ends with `conv_start` high in the cycle after the 18th clock edge following release.
- R2: A falling edge on `pin_n` passes through a two-stage synchronizer and starts a reset. `init_busy` rises after the 3rd clock edge that follows the pin going low.
- R3: After any reset trigger, `init_busy` and `cfg_rst` stay high for exactly `INIT_CYC` (18) cycles. `conv_start` is then high for exactly one cycle, in the cycle right after `init_busy` falls.
- R4: A low pulse shorter than `LOW_LIM` cycles never asserts `pwr_dn`, and the full reset and initialization sequence still completes.
- R5: If `pin_n` stays low, `pwr_dn` rises after the (`LOW_LIM`+3)th clock edge following the pin going low. This means the pin must be low for more than `LOW_LIM` (1024) synchronized cycles. It stays 0 after the (`LOW_LIM`+2)th edge.
- R6: `pwr_dn` holds `cfg_rst` high. When `pin_n` returns high, `pwr_dn` falls after the 3rd edge, and a fresh 18-cycle initialization ending in `conv_start` follows.
- R7: A one-cycle `op_rst` strobe starts a reset. `init_busy` is high after the next edge, and `conv_start` follows after the 19th edge.
- R8: `op_rst` has no effect while `pwr_dn` is high: `init_busy` stays 0 and `pwr_dn` stays 1.
- R9: A `wr_stb` to address `FA0`, `FA1` or `FA2` (defaults 1, 8, 9) while idle gives a one-cycle `filt_rst` after the next edge. A write to any other address gives none.
- R10: Writes while `init_busy` or `pwr_dn` is high do not raise `filt_rst`.
- R11: A new reset trigger during initialization restarts the 18-cycle count, and no `conv_start` occurs before the restarted count ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Power-on reset, active low |
| pin_n | input | 1 | Shared reset/power-down pin, active low, asynchronous |
| op_rst | input | 1 | Reset-opcode strobe from the command decoder |
| wr_stb | input | 1 | Register-write notification strobe |
| wr_addr | input | AW | Address of the written register |
| cfg_rst | output | 1 | Holds configuration registers at defaults |
| pwr_dn | output | 1 | Power-down enable |
| init_busy | output | 1 | Initialization window in progress |
| conv_start | output | 1 | One-cycle pulse that starts the conversion cycle |
| filt_rst | output | 1 | One-cycle digital filter reset |

## Verification
Every result has a fixed latency counted from the clock edge after a stimulus:
- A pin fall shows on `init_busy` after the 3rd edge, and its `conv_start` comes after the 21st edge.
- An opcode strobe shows on `init_busy` after the 1st edge, and its `conv_start` comes after the 19th edge.
- `filt_rst` appears after the 1st edge following a write.
- `pwr_dn` rises after edge `LOW_LIM`+3 and falls after edge 3 of the release.

The bench drives inputs on falling clock edges and counts falling edges from each stimulus. At every falling edge it compares the outputs with values its functions derive from these offsets. Random pulse widths and random write addresses exercise the same checks alongside the directed corner cases.

// File: rtl/pdrst_seq.sv
module pdrst_seq #(
  parameter int LOW_LIM  = 1024,
  parameter int INIT_CYC = 18,
  parameter int AW       = 4,
  parameter int FA0      = 1,
  parameter int FA1      = 8,
  parameter int FA2      = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_n,
  input  logic          op_rst,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  output logic          cfg_rst,
  output logic          pwr_dn,
  output logic          init_busy,
  output logic          conv_start,
  output logic          filt_rst
);
  localparam int LW = $clog2(LOW_LIM + 1);
  localparam int IW = $clog2(INIT_CYC + 1);
  localparam logic [LW-1:0] LIM_V  = LW'(LOW_LIM);
  localparam logic [IW-1:0] INIT_V = IW'(INIT_CYC);

  logic [2:0]    sync_q;
  logic [LW-1:0] low_cnt;
  logic [IW-1:0] init_cnt;
  logic          pd_q, conv_q, filt_q;

  wire pin_s   = sync_q[1];
  wire fall    = sync_q[2] & ~sync_q[1];
  wire pd_exit = pd_q & pin_s;
  wire trig    = fall | (op_rst & ~pd_q);
  wire hit     = (wr_addr == AW'(FA0)) || (wr_addr == AW'(FA1)) || (wr_addr == AW'(FA2));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], pin_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      low_cnt <= '0;
      pd_q    <= 1'b0;
    end else if (pin_s) begin
      low_cnt <= '0;
      pd_q    <= 1'b0;
    end else begin
      if (low_cnt != LIM_V) low_cnt <= low_cnt + 1'b1;
      else                  pd_q    <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                init_cnt <= INIT_V;
    else if (trig || pd_exit)  init_cnt <= INIT_V;
    else if (init_cnt != '0)   init_cnt <= init_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      conv_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      conv_q <= (init_cnt == IW'(1)) && !trig && !pd_exit;
      filt_q <= wr_stb && hit && (init_cnt == '0) && !pd_q;
    end

  assign init_busy  = (init_cnt != '0);
  assign pwr_dn     = pd_q;
  assign cfg_rst    = init_busy | pd_q;
  assign conv_start = conv_q;
  assign filt_rst   = filt_q;

  // R3
  conv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R3
  conv_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (!init_busy && $past(init_busy)));
  // R5
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_dn) |-> ($past(low_cnt) == LIM_V));
  // R6
  pd_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> cfg_rst);
  // R8
  pd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && $past(pwr_dn)) |-> !init_busy);
  // R9
  filt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filt_rst |-> $past(wr_stb));
endmodule

// File: tb/sim_pdrst_seq.sv
module sim_pdrst_seq;
  localparam int LIM = 1024;
  logic clk = 0, rst_n = 0, pin_n = 1, op_rst = 0, wr_stb = 0;
  logic [3:0] wr_addr = '0;
  logic cfg_rst, pwr_dn, init_busy, conv_start, filt_rst;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pdrst_seq u0 (.clk(clk), .rst_n(rst_n), .pin_n(pin_n), .op_rst(op_rst),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .cfg_rst(cfg_rst), .pwr_dn(pwr_dn),
    .init_busy(init_busy), .conv_start(conv_start), .filt_rst(filt_rst));

  function automatic bit exp_filt(input logic [3:0] a, input bit busy);
    return (a == 4'd1 || a == 4'd8 || a == 4'd9) && !busy;
  endfunction
  function automatic bit exp_busy(input int k, input int first);
    return k >= first && k <= first + 17;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40; i++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cfg_rst", cfg_rst, 1); chk("R1 busy", init_busy, 1);
    chk("R1 pwr_dn", pwr_dn, 0); chk("R1 conv", conv_start, 0); chk("R1 filt", filt_rst, 0);
    rst_n = 1;
    for (int k = 1; k <= 19; k++) begin
      @(negedge clk);
      chk("R1 busy", init_busy, k <= 17);
      chk("R1 conv", conv_start, k == 18);
    end
    wait_idle();

    // R2 R3 directed short pulse
    pin_n = 0;
    for (int k = 1; k <= 22; k++) begin
      @(negedge clk);
      chk("R2 busy", init_busy, exp_busy(k, 3));
      chk("R3 cfg_rst", cfg_rst, exp_busy(k, 3));
      chk("R3 conv", conv_start, k == 21);
      if (k == 5) pin_n = 1;
    end
    wait_idle();

    // R7 R10 opcode reset, write during busy
    op_rst = 1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      op_rst = 0;
      chk("R7 busy", init_busy, exp_busy(k, 1));
      chk("R7 conv", conv_start, k == 19);
      if (k == 3) begin wr_stb = 1; wr_addr = 4'd8; end
      else wr_stb = 0;
      if (k == 4) chk("R10 filt during busy", filt_rst, 0);
    end
    wait_idle();

    // R11 retrigger
    op_rst = 1;
    @(negedge clk); op_rst = 0;
    repeat (9) @(negedge clk);
    op_rst = 1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      op_rst = 0;
      chk("R11 busy", init_busy, exp_busy(k, 1));
      chk("R11 conv", conv_start, k == 19);
    end
    wait_idle();

    // R9 directed writes
    foreach (wr_addr[i]) ;
    for (int a = 0; a < 16; a++) begin
      wr_stb = 1; wr_addr = 4'(a);
      @(negedge clk); wr_stb = 0;
      chk("R9 filt", filt_rst, exp_filt(4'(a), 0));
      @(negedge clk);
      chk("R9 filt width", filt_rst, 0);
    end

    // R5 R6 R8 long hold into power-down
    pin_n = 0;
    for (int k = 1; k <= LIM + 3; k++) begin
      @(negedge clk);
      if (k == LIM + 2) chk("R5 pd early", pwr_dn, 0);
      if (k == LIM + 3) chk("R5 pd set", pwr_dn, 1);
    end
    chk("R6 cfg_rst in pd", cfg_rst, 1);
    op_rst = 1;
    @(negedge clk); op_rst = 0;
    chk("R8 busy", init_busy, 0); chk("R8 pd", pwr_dn, 1);
    wr_stb = 1; wr_addr = 4'd1;
    @(negedge clk); wr_stb = 0;
    chk("R10 filt in pd", filt_rst, 0);
    pin_n = 1;
    for (int k = 1; k <= 22; k++) begin
      @(negedge clk);
      chk("R6 pd", pwr_dn, k <= 2);
      chk("R6 busy", init_busy, exp_busy(k, 3));
      chk("R6 cfg_rst", cfg_rst, k <= 2 || exp_busy(k, 3));
      chk("R6 conv", conv_start, k == 21);
    end
    wait_idle();

    // random mix
    for (int it = 0; it < 60; it++) begin
      if ($urandom_range(1, 0) == 0) begin
        logic [3:0] a;
        a = 4'($urandom_range(15, 0));
        wr_stb = 1; wr_addr = a;
        @(negedge clk); wr_stb = 0;
        chk("R9 rnd filt", filt_rst, exp_filt(a, 0));
        @(negedge clk);
      end else begin
        int w;
        w = int'($urandom_range(200, 1));
        pin_n = 0;
        for (int k = 1; k <= w + 25; k++) begin
          @(negedge clk);
          if (k <= 22) begin
            chk("R4 busy", init_busy, exp_busy(k, 3));
            chk("R4 conv", conv_start, k == 21);
          end
          chk("R4 pd", pwr_dn, 0);
          if (k == w) pin_n = 1;
        end
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule